// File: doc/BRIEF.md
# Luma Residual Block Dispatcher

This block walks through the sixteen 4x4 luma residual blocks of one macroblock. For each block, or pair of blocks, it decides whether a transform unit must run a full inverse transform with add, a DC-only update, or no work at all. It makes that decision from a per-macroblock nonzero-count table and from per-block flags that mark a nonzero DC coefficient. For each piece of work it places one command on a simple valid/done handshake. The command carries the block index, the pixel destination (a base address plus a per-block offset) and the coefficient buffer address.

There are two modes, selected at start. In the per-block mode, each block with a nonzero count gets a full transform, and every other block is skipped. In the paired mode, blocks are taken two at a time as an even block and the odd block beside it. A nonzero count in either block sends both blocks through the full transform. If both counts are zero but either block has a nonzero DC coefficient, the pair gets one DC-only update that covers both blocks. If neither condition holds, the pair is dropped.

Top module: `resid_dispatch`

## Requirements
- R1: A one-cycle `start` pulse while idle raises `busy` at the next clock edge and latches `intra`. `busy` stays high until the last block or pair is resolved. A `start` pulse or a change of `intra` while `busy` is high has no effect on the running sequence.
- R2: The count for luma block n (n = 0..15) is the byte at entry index k of `nnz_tab`, stored at bits [8k+7:8k]. The k values for n = 0..15 are 12,13,20,21,14,15,22,23,28,29,36,37,30,31,38,39. No other entry affects behaviour.
- R3: In per-block mode (`intra`=0), block n gets exactly one full command (`cmd_kind`=1) if its count is nonzero and no command otherwise. Commands are issued in ascending block order.
- R4: Each command carries `cmd_dst` = `pix_base` + `blk_off[16n+15:16n]` and `cmd_addr` = `coef_base` + 64*n, where n is `cmd_blk`.
- R5: Only one command is outstanding at a time. Its fields stay stable while `cmd_valid` is high and `cmd_done` is low.
- R6: In paired mode (`intra`=1), when either count of pair (2p, 2p+1) is nonzero, full commands are issued for block 2p and then for block 2p+1.
- R7: In paired mode, when both counts of a pair are zero and `dc_nz` bit 2p or bit 2p+1 is set, exactly one DC command (`cmd_kind`=2) is issued with `cmd_blk`=2p.
- R8: In paired mode, a pair with zero counts and both DC flags clear produces no command.
- R9: Each evaluation that produces no command takes one cycle. With nothing to do, `busy` stays high for 16 cycles in per-block mode and for 8 cycles in paired mode.
- R10: After reset, `busy` and `cmd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin one macroblock |
| intra | input | 1 | 1 = paired mode, 0 = per-block mode |
| nnz_tab | input | 384 | 48 count bytes |
| dc_nz | input | 16 | Nonzero DC flag per block |
| blk_off | input | 16*OFFW | Per-block pixel offsets |
| pix_base | input | ADDRW | Pixel base address |
| coef_base | input | ADDRW | Coefficient buffer base |
| cmd_done | input | 1 | Transform unit finished the current command |
| busy | output | 1 | Macroblock in progress |
| cmd_valid | output | 1 | Command outstanding |
| cmd_kind | output | 2 | 1 = full transform, 2 = DC pair |
| cmd_blk | output | 4 | Block index |
| cmd_dst | output | ADDRW | Pixel destination |
| cmd_addr | output | ADDRW | Coefficient address |

## Verification
The stimulus writes nonzero bytes into count entries that belong to no luma block. A dispatcher that indexes the table in raster order would then issue commands the model does not expect. Paired-mode cases cover a pair with only the odd count set, which must still produce two full commands, and pairs where only the odd DC flag is set, which must produce one DC command on the even index. A design that tested only the even member of a pair would drop these. A stray `start` and a flip of `intra` during a run check that the mode is latched; a design that reads the mode live would switch decision rules partway through. Empty macroblocks check the one-cycle-per-evaluation timing in both modes.

// File: rtl/resid_dispatch.sv
module resid_dispatch #(
  parameter int ADDRW = 32,
  parameter int OFFW  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               intra,
  input  logic [383:0]       nnz_tab,
  input  logic [15:0]        dc_nz,
  input  logic [16*OFFW-1:0] blk_off,
  input  logic [ADDRW-1:0]   pix_base,
  input  logic [ADDRW-1:0]   coef_base,
  input  logic               cmd_done,
  output logic               busy,
  output logic               cmd_valid,
  output logic [1:0]         cmd_kind,
  output logic [3:0]         cmd_blk,
  output logic [ADDRW-1:0]   cmd_dst,
  output logic [ADDRW-1:0]   cmd_addr
);
  localparam int NBLK     = 16;
  localparam int BLK_SHFT = 6;
  localparam logic [1:0] K_FULL = 2'd1;
  localparam logic [1:0] K_DC   = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_WAIT} st_t;
  st_t st;
  logic [3:0] idx;
  logic       mode_r, pend2;

  logic [NBLK-1:0] nz;
  for (genvar n = 0; n < NBLK; n++) begin : g_nz
    localparam int COL  = (n & 1) + ((n >> 2) & 1) * 2;
    localparam int ROW  = ((n >> 1) & 1) + ((n >> 3) & 1) * 2;
    localparam int SLOT = 12 + COL + ROW * 8;
    assign nz[n] = |nnz_tab[SLOT*8 +: 8];
  end

  wire [3:0] odd     = {idx[3:1], 1'b1};
  wire       full_hit = mode_r ? (nz[idx] | nz[odd]) : nz[idx];
  wire       dc_hit   = mode_r & (dc_nz[idx] | dc_nz[odd]);
  wire       last     = mode_r ? (idx == 4'd14) : (idx == 4'd15);
  wire [3:0] step     = mode_r ? 4'd2 : 4'd1;
  wire [3:0] nblk     = (st == S_WAIT) ? odd : idx;
  wire [ADDRW-1:0] dst_n  = pix_base + ADDRW'(blk_off[nblk*OFFW +: OFFW]);
  wire [ADDRW-1:0] addr_n = coef_base + (ADDRW'(nblk) << BLK_SHFT);

  assign busy      = (st != S_IDLE);
  assign cmd_valid = (st == S_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      mode_r   <= 1'b0;
      pend2    <= 1'b0;
      cmd_kind <= '0;
      cmd_blk  <= '0;
      cmd_dst  <= '0;
      cmd_addr <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st     <= S_EVAL;
          idx    <= '0;
          mode_r <= intra;
        end
        S_EVAL: begin
          if (full_hit || dc_hit) begin
            st       <= S_WAIT;
            cmd_kind <= full_hit ? K_FULL : K_DC;
            cmd_blk  <= idx;
            cmd_dst  <= dst_n;
            cmd_addr <= addr_n;
            pend2    <= mode_r & full_hit;
          end else if (last) begin
            st <= S_IDLE;
          end else begin
            idx <= idx + step;
          end
        end
        S_WAIT: if (cmd_done) begin
          if (pend2) begin
            pend2    <= 1'b0;
            cmd_blk  <= odd;
            cmd_dst  <= dst_n;
            cmd_addr <= addr_n;
          end else if (last) begin
            st <= S_IDLE;
          end else begin
            st  <= S_EVAL;
            idx <= idx + step;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_blk) && $stable(cmd_dst) && $stable(cmd_kind));
  assert_valid_in_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);
  assert_inter_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !mode_r |-> cmd_kind == K_FULL);
  assert_dc_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind == K_DC |-> !cmd_blk[0]);
  assert_addr_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_addr - coef_base) == (ADDRW'(cmd_blk) << BLK_SHFT));
  assert_busy_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(mode_r));
endmodule

// File: tb/resid_dispatch_tb.sv
module resid_dispatch_tb;
  localparam int ADDRW = 32;
  localparam int OFFW  = 16;

  logic clk = 0, rst_n = 0, start = 0, intra = 0, cmd_done = 0;
  logic [383:0] nnz_tab = '0;
  logic [15:0] dc_nz = '0;
  logic [16*OFFW-1:0] blk_off;
  logic [ADDRW-1:0] pix_base = 32'h0010_0000, coef_base = 32'h0000_4000;
  logic busy, cmd_valid;
  logic [1:0] cmd_kind;
  logic [3:0] cmd_blk;
  logic [ADDRW-1:0] cmd_dst, cmd_addr;

  int checks = 0, errors = 0, wd = 0;
  int kmap[16] = '{12,13,20,21,14,15,22,23,28,29,36,37,30,31,38,39};
  int q_kind[$], q_blk[$];

  always #5 clk = ~clk;

  resid_dispatch #(.ADDRW(ADDRW), .OFFW(OFFW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .intra(intra), .nnz_tab(nnz_tab),
    .dc_nz(dc_nz), .blk_off(blk_off), .pix_base(pix_base), .coef_base(coef_base),
    .cmd_done(cmd_done), .busy(busy), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_blk(cmd_blk), .cmd_dst(cmd_dst), .cmd_addr(cmd_addr));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cnt(input int n);
    return int'(nnz_tab[kmap[n]*8 +: 8]);
  endfunction

  task automatic build(input bit m);
    q_kind.delete(); q_blk.delete();
    if (!m) begin
      for (int n = 0; n < 16; n++)
        if (cnt(n) != 0) begin q_kind.push_back(1); q_blk.push_back(n); end
    end else begin
      for (int p = 0; p < 16; p += 2) begin
        if (cnt(p) != 0 || cnt(p+1) != 0) begin
          q_kind.push_back(1); q_blk.push_back(p);
          q_kind.push_back(1); q_blk.push_back(p+1);
        end else if (dc_nz[p] || dc_nz[p+1]) begin
          q_kind.push_back(2); q_blk.push_back(p);
        end
      end
    end
  endtask

  task automatic run_mb(input bit m, input bit poke, input int exp_cyc);
    int cyc = 0;
    int issued = 0;
    build(m);
    @(negedge clk); start = 1; intra = m;
    @(negedge clk); start = 0;
    chk(busy === 1'b1, "R1 busy after start", busy, 1);
    while (busy && cyc < 3000) begin
      if (cmd_valid) begin
        logic [3:0] b0;
        b0 = cmd_blk;
        if (q_blk.size() == 0) begin
          chk(0, "R3/R8 unexpected command", cmd_blk, -1);
        end else begin
          int eb = q_blk[0];
          chk(cmd_blk == 4'(eb), m ? "R6/R7 block index" : "R2/R3 block index", cmd_blk, eb);
          chk(int'(cmd_kind) == q_kind[0], m ? "R6/R7 kind" : "R3 kind", cmd_kind, q_kind[0]);
          chk(cmd_dst == pix_base + ADDRW'(blk_off[eb*OFFW +: OFFW]), "R4 dst", cmd_dst,
              pix_base + blk_off[eb*OFFW +: OFFW]);
          chk(cmd_addr == coef_base + ADDRW'(eb*64), "R4 addr", cmd_addr, coef_base + eb*64);
          void'(q_blk.pop_front()); void'(q_kind.pop_front());
        end
        issued++;
        @(negedge clk);
        chk(cmd_valid && cmd_blk == b0, "R5 held until done", cmd_blk, b0);
        if (poke) begin start = 1; intra = !m; end
        @(negedge clk); start = 0; intra = m; cmd_done = 1;
        @(negedge clk); cmd_done = 0;
        cyc += 3;
      end else begin
        @(negedge clk); cyc++;
      end
    end
    chk(q_blk.size() == 0, m ? "R6/R7 missing command" : "R3 missing command", q_blk.size(), 0);
    chk(busy === 1'b0, "R1 busy falls", busy, 0);
    if (exp_cyc >= 0) chk(cyc == exp_cyc && issued == 0, "R9 empty timing", cyc, exp_cyc);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 16; n++) blk_off[n*OFFW +: OFFW] = 16'(n*37 + 5);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && cmd_valid === 1'b0, "R10 reset state", {busy, cmd_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    for (int k = 0; k < 48; k++) nnz_tab[k*8 +: 8] = 8'hA5;
    for (int n = 0; n < 16; n++) nnz_tab[kmap[n]*8 +: 8] = 8'h00;
    run_mb(0, 0, 16);
    run_mb(1, 0, 8);
    nnz_tab[kmap[0]*8 +: 8] = 3;
    nnz_tab[kmap[5]*8 +: 8] = 1;
    nnz_tab[kmap[10]*8 +: 8] = 7;
    nnz_tab[kmap[15]*8 +: 8] = 2;
    run_mb(0, 0, -1);
    run_mb(0, 1, -1);
    dc_nz = 16'b0000_1000_0000_1100;
    run_mb(1, 0, -1);
    for (int n = 0; n < 16; n++) nnz_tab[kmap[n]*8 +: 8] = 0;
    nnz_tab[kmap[7]*8 +: 8] = 4;
    dc_nz = 16'b1010_0000_0010_0010;
    run_mb(1, 1, -1);
    for (int n = 0; n < 16; n++) nnz_tab[kmap[n]*8 +: 8] = 8'(n + 1);
    pix_base = 32'h0020_0100; coef_base = 32'h0000_8000;
    run_mb(0, 0, -1);
    run_mb(1, 0, -1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule